// File: doc/BRIEF.md
# Feedback Frequency Tracker

This block estimates the frequency of a digital input by steering an internal oscillator toward it. A phase accumulator adds a tuning word on every clock, and its top bit serves as a reference square wave. A digital frequency comparator watches the rising edges of the input and of the reference. Whenever one of the two shows two rising edges in a row with no edge of the other in between, the comparator issues a single correction. The correction moves the tuning word up or down by a step size.

Near the right value the tuning word swings back and forth in a triangle around the input frequency. Each ramp has a fixed slope for a given input. The block counts how often the direction of correction flips and raises a lock flag after enough flips. It drops the flag when corrections keep going the same way for too long. The estimate output is the midpoint of the two most recent turning points of the triangle. In frequency terms the estimate is `estimate / 2^W` times the clock rate.

Top module: `freq_track_loop`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tune_word` loads `init_word`, and `locked`, `estimate`, `ref_sq` and the phase accumulator clear to 0.
- R2: The phase accumulator adds the current `tune_word` on every clock edge. `ref_sq` is its most significant bit, so a zero tuning word freezes `ref_sq`.
- R3: A rising edge of a signal is a clock edge where the signal is 1 and was 0 at the previous edge. Two input rising edges with no reference rising edge between them request one step up. Two reference rising edges with no input rising edge between them request one step down. When both signals rise at the same edge, the edge history is forgotten. A request seen at edge k changes `tune_word` at edge k+1, and nothing else changes it.
- R4: A step up that would pass 2^W-1 leaves `tune_word` at 2^W-1.
- R5: A step down larger than the current `tune_word` leaves it at 0.
- R6: A correction whose direction differs from the previous correction is a reversal. `locked` rises on the correction that brings the saturating reversal count to LOCK_REVS.
- R7: Every non-reversing correction extends a run length, and every reversal resets it to 1. When the run length exceeds UNLOCK_RUN, `locked` clears and the reversal count restarts from 0 on that same correction.
- R8: On every reversal after the first, `estimate` becomes floor((a+b)/2). Here a and b are the tuning word values just before the current reversing correction and just before the previous one. It changes at no other time.
- R9: `step_word` is sampled at the edge where each correction is applied, so a new step size takes effect from the next correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Unknown-frequency input, synchronous to clk |
| init_word | input | W | Tuning word loaded at reset |
| step_word | input | W | Size of each correction |
| ref_sq | output | 1 | Reference square wave (accumulator MSB) |
| tune_word | output | W | Current tuning word |
| locked | output | 1 | Loop considered settled |
| estimate | output | W | Midpoint of the last two turning points |

## Verification
The assertions assume that `sig_in` is already synchronous to `clk` and stable around each rising edge. They also assume that `init_word` and `step_word` are settled whenever a correction or a reset is applied. The bench produces `sig_in` from a counter that toggles on the falling clock edge, with half-periods of one clock and up. It changes `step_word` only on the falling edge. Every run stays inside these assumptions, including the fastest input the sampling can resolve and an input held at 0.

// File: rtl/ftl_pkg.sv
// Shared types for the feedback frequency tracker.
// Assumes nothing beyond SystemVerilog packages.
package ftl_pkg;
    // Direction of one tuning correction
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Which signal produced the most recent rising edge
    typedef enum logic {
        SRC_INPUT = 1'b0,
        SRC_REF   = 1'b1
    } src_e;
endpackage

// File: rtl/ftl_nco.sv
// Phase accumulator: adds the tuning word each clock; its MSB is the
// reference square wave. Assumes tune_word is driven from the same clock.
module ftl_nco #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tune_word,
    output logic         ref_sq
);
    logic [W-1:0] phase_acc;

    // Advance phase by the tuning word each clock
    always_ff @(posedge clk) begin
        if (!rst_n) phase_acc <= '0;
        else        phase_acc <= phase_acc + tune_word;
    end

    assign ref_sq = phase_acc[W-1];

    AST_ZERO_WORD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_word == '0) |=> $stable(ref_sq)); // R2
endmodule

// File: rtl/ftl_freq_cmp.sv
// Digital frequency comparator. Tracks the source of the latest rising
// edge and issues a one-cycle correction when one source rises twice in a
// row. Assumes sig_in is synchronous to clk.
module ftl_freq_cmp
    import ftl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic ref_sq,
    output logic upd_valid,
    output dir_e upd_dir
);
    logic in_q, ref_q, have_edge;
    src_e last_src;
    logic rise_in, rise_ref;

    // Rising-edge detection against the previous sampled value
    always_comb begin
        rise_in  = sig_in & ~in_q;
        rise_ref = ref_sq & ~ref_q;
    end

    // Edge history and correction request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q      <= 1'b0;
            ref_q     <= 1'b0;
            have_edge <= 1'b0;
            last_src  <= SRC_INPUT;
            upd_valid <= 1'b0;
            upd_dir   <= DIR_DOWN;
        end else begin
            in_q      <= sig_in;
            ref_q     <= ref_sq;
            upd_valid <= 1'b0;
            if (rise_in && rise_ref) begin
                have_edge <= 1'b0;
            end else if (rise_in) begin
                if (have_edge && last_src == SRC_INPUT) begin
                    upd_valid <= 1'b1;
                    upd_dir   <= DIR_UP;
                end
                have_edge <= 1'b1;
                last_src  <= SRC_INPUT;
            end else if (rise_ref) begin
                if (have_edge && last_src == SRC_REF) begin
                    upd_valid <= 1'b1;
                    upd_dir   <= DIR_DOWN;
                end
                have_edge <= 1'b1;
                last_src  <= SRC_REF;
            end
        end
    end
endmodule

// File: rtl/ftl_track_cnt.sv
// Saturating up/down counter holding the tuning word. Moves by step_word
// once per correction. Assumes init_word is stable during reset.
module ftl_track_cnt
    import ftl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] init_word,
    input  logic [W-1:0] step_word,
    input  logic         upd_valid,
    input  dir_e         upd_dir,
    output logic [W-1:0] tune_word
);
    localparam logic [W-1:0] WORD_MAX = '1;

    logic [W:0]   sum_up;
    logic [W-1:0] next_word;

    // Saturating next value for either direction
    always_comb begin
        sum_up = {1'b0, tune_word} + {1'b0, step_word};
        if (upd_dir == DIR_UP)
            next_word = sum_up[W] ? WORD_MAX : sum_up[W-1:0];
        else
            next_word = (step_word > tune_word) ? '0 : tune_word - step_word;
    end

    // Apply one correction per request
    always_ff @(posedge clk) begin
        if (!rst_n)         tune_word <= init_word;
        else if (upd_valid) tune_word <= next_word;
    end

    AST_HOLD_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(tune_word)); // R3
    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_dir == DIR_UP && tune_word == WORD_MAX) |=> tune_word == WORD_MAX); // R4
    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_dir == DIR_DOWN && step_word >= tune_word) |=> tune_word == '0); // R5
endmodule

// File: rtl/ftl_lock_est.sv
// Lock detector and estimator. Counts direction reversals, tracks the run
// length of same-direction corrections, and averages the last two turning
// points. Assumes tune_word is the value before the current correction.
module ftl_lock_est
    import ftl_pkg::*;
#(
    parameter int W          = 32,
    parameter int LOCK_REVS  = 8,
    parameter int UNLOCK_RUN = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_valid,
    input  dir_e         upd_dir,
    input  logic [W-1:0] tune_word,
    output logic         locked,
    output logic [W-1:0] estimate
);
    localparam int RW = $clog2(LOCK_REVS + 1);
    localparam int NW = $clog2(UNLOCK_RUN + 2);
    localparam logic [RW-1:0] REV_MAX = RW'(LOCK_REVS);
    localparam logic [NW-1:0] RUN_LIM = NW'(UNLOCK_RUN);

    logic [RW-1:0] rev_cnt, rev_nx;
    logic [NW-1:0] run_cnt, run_nx;
    logic          have_prev, turn_valid, reversal;
    dir_e          prev_dir;
    logic [W-1:0]  turn_word;
    logic [W:0]    turn_sum;

    // Next-state helpers for counters and the midpoint
    always_comb begin
        reversal = have_prev && (upd_dir != prev_dir);
        rev_nx   = (rev_cnt == REV_MAX) ? rev_cnt : rev_cnt + 1'b1;
        run_nx   = (run_cnt > RUN_LIM) ? run_cnt : run_cnt + 1'b1;
        turn_sum = {1'b0, turn_word} + {1'b0, tune_word};
    end

    // Update lock state and estimate on each correction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev_cnt    <= '0;
            run_cnt    <= '0;
            have_prev  <= 1'b0;
            prev_dir   <= DIR_DOWN;
            turn_valid <= 1'b0;
            turn_word  <= '0;
            locked     <= 1'b0;
            estimate   <= '0;
        end else if (upd_valid) begin
            have_prev <= 1'b1;
            prev_dir  <= upd_dir;
            if (reversal) begin
                rev_cnt    <= rev_nx;
                run_cnt    <= NW'(1);
                turn_word  <= tune_word;
                turn_valid <= 1'b1;
                if (turn_valid) estimate <= turn_sum[W:1];
                if (rev_nx == REV_MAX) locked <= 1'b1;
            end else begin
                run_cnt <= run_nx;
                if (run_nx > RUN_LIM) begin
                    locked  <= 1'b0;
                    rev_cnt <= '0;
                end
            end
        end
    end

    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> rev_cnt == REV_MAX); // R6
    AST_RUN_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt > RUN_LIM) |-> !locked); // R7
    AST_EST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(estimate)); // R8
endmodule

// File: rtl/freq_track_loop.sv
// Top of the feedback frequency tracker: oscillator, comparator, tuning
// counter and lock/estimate stage in a closed loop. Assumes sig_in is
// synchronous to clk.
module freq_track_loop #(
    parameter int W          = 32,
    parameter int LOCK_REVS  = 8,
    parameter int UNLOCK_RUN = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sig_in,
    input  logic [W-1:0] init_word,
    input  logic [W-1:0] step_word,
    output logic         ref_sq,
    output logic [W-1:0] tune_word,
    output logic         locked,
    output logic [W-1:0] estimate
);
    logic          upd_valid;
    ftl_pkg::dir_e upd_dir;

    ftl_nco #(.W(W)) u_nco (
        .clk(clk), .rst_n(rst_n), .tune_word(tune_word), .ref_sq(ref_sq)
    );

    ftl_freq_cmp u_cmp (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .ref_sq(ref_sq),
        .upd_valid(upd_valid), .upd_dir(upd_dir)
    );

    ftl_track_cnt #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .init_word(init_word), .step_word(step_word),
        .upd_valid(upd_valid), .upd_dir(upd_dir), .tune_word(tune_word)
    );

    ftl_lock_est #(.W(W), .LOCK_REVS(LOCK_REVS), .UNLOCK_RUN(UNLOCK_RUN)) u_lock (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_dir(upd_dir),
        .tune_word(tune_word), .locked(locked), .estimate(estimate)
    );
endmodule

// File: tb/freq_track_loop_bench.sv
`timescale 1ns/1ps
module freq_track_loop_bench;
    localparam int W  = 16;
    localparam int LR = 4;
    localparam int UR = 6;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sig_in = 1'b0;
    logic [W-1:0] init_word = '0;
    logic [W-1:0] step_word = '0;
    logic         ref_sq, locked;
    logic [W-1:0] tune_word, estimate;

    int n_chk = 0, n_fail = 0;
    int half = 0, tgl_cnt = 0;
    bit cmp_en = 0, watch_fall = 0, saw_fall = 0, saw_lock = 0, done = 0;

    freq_track_loop #(.W(W), .LOCK_REVS(LR), .UNLOCK_RUN(UR)) u_freq_track_loop (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .init_word(init_word),
        .step_word(step_word), .ref_sq(ref_sq), .tune_word(tune_word),
        .locked(locked), .estimate(estimate)
    );

    always #5 clk = ~clk;

    // Behavioural reference model state
    int m_acc, m_f, m_est, m_tp, m_rev, m_run;
    bit m_inq, m_rq, m_have, m_last, m_v, m_up, m_hp, m_pd, m_tpv, m_lk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_f = int'(init_word); m_est = 0; m_tp = 0; m_rev = 0; m_run = 0;
            m_inq = 0; m_rq = 0; m_have = 0; m_last = 0; m_v = 0; m_up = 0;
            m_hp = 0; m_pd = 0; m_tpv = 0; m_lk = 0;
            cmp_en = 1;
        end else begin
            bit r, ein, eref, nv, nup, nhave, nlast;
            int nf;
            r = m_acc[W-1];
            ein = sig_in && !m_inq;
            eref = r && !m_rq;
            nv = 0; nup = m_up; nhave = m_have; nlast = m_last;
            if (ein && eref) nhave = 0;
            else if (ein) begin
                if (m_have && m_last == 0) begin nv = 1; nup = 1; end
                nhave = 1; nlast = 0;
            end else if (eref) begin
                if (m_have && m_last == 1) begin nv = 1; nup = 0; end
                nhave = 1; nlast = 1;
            end
            nf = m_f;
            if (m_v) begin
                if (m_up) nf = (m_f + int'(step_word) > MAXV) ? MAXV : m_f + int'(step_word);
                else      nf = (int'(step_word) > m_f) ? 0 : m_f - int'(step_word);
                if (m_hp && m_up != m_pd) begin
                    if (m_rev < LR) m_rev++;
                    m_run = 1;
                    if (m_tpv) m_est = (m_tp + m_f) / 2;
                    m_tp = m_f; m_tpv = 1;
                    if (m_rev == LR) m_lk = 1;
                end else begin
                    if (m_run <= UR) m_run++;
                    if (m_run > UR) begin m_lk = 0; m_rev = 0; end
                end
                m_pd = m_up; m_hp = 1;
            end
            m_acc = (m_acc + m_f) & MAXV;
            m_f = nf; m_v = nv; m_up = nup; m_have = nhave; m_last = nlast;
            m_inq = sig_in; m_rq = r;
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Input generator and per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check("R2 ref_sq", int'(ref_sq), int'(m_acc[W-1]));
            check("R3 tune_word", int'(tune_word), m_f);
            check("R6 locked", int'(locked), int'(m_lk));
            check("R8 estimate", int'(estimate), m_est);
            if (locked) saw_lock = 1;
            if (watch_fall && !locked) saw_fall = 1;
        end
        if (half == 0) sig_in <= 1'b0;
        else if (tgl_cnt + 1 >= half) begin sig_in <= ~sig_in; tgl_cnt <= 0; end
        else tgl_cnt <= tgl_cnt + 1;
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(int iw, int sw, int hp);
        @(negedge clk);
        rst_n = 0; init_word = W'(iw); step_word = W'(sw); half = hp;
        run(3);
        check("R1 reset tune_word", int'(tune_word), iw);
        check("R1 reset locked", int'(locked), 0);
        check("R1 reset estimate", int'(estimate), 0);
        check("R1 reset ref_sq", int'(ref_sq), 0);
        rst_n = 1;
    endtask

    initial begin
        // Tracking a period-20 input, lock and estimate
        do_reset(1000, 512, 10);
        run(20000);
        check("R6 lock reached", int'(saw_lock), 1);
        check("R8 estimate near 3277", int'((estimate > 2765 && estimate < 3789)), 1);
        // R9: smaller step mid-run
        step_word = W'(128);
        run(5000);
        // R7: jump to a much faster input breaks lock
        watch_fall = 1; half = 3;
        run(4000);
        watch_fall = 0;
        check("R7 unlock on long run", int'(saw_fall), 1);
        // R4: input faster than any reachable reference
        do_reset(60000, 4096, 1);
        run(300);
        check("R4 clamp at max", int'(tune_word), MAXV);
        // R5: silent input drives the word down to zero
        do_reset(1000, 300, 0);
        run(4000);
        check("R5 clamp at zero", int'(tune_word), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule